// File: doc/BRIEF.md
# Indirect and Streaming Memory Window

This block lets a host reach a large internal word-addressed RAM through four 32-bit registers on a small register bus with byte strobes. One register pair gives random access. The host loads a byte address into a pointer register, and the paired data register then reads or writes the word at that address. The pointer stays where it is, so repeated data accesses all hit the same word.

The second pair gives streaming access. The host loads a start address. Every access to the streaming data register uses the word under the pointer and then moves the pointer on by one word. Reading the streaming pointer register returns the live pointer, so software can tell where the next access will land. Streaming writes complete in the cycle they are presented, which lets software clear or load long runs of memory at one word per clock.

The bus handshake works as follows. The host raises `bus_sel` and holds the offset, strobes and write data until `bus_ready` is high. A write finishes in the same cycle. A read finishes one cycle later, and its data is valid only in that cycle.

Top module: `memwin_top`

## Requirements
- R1: After reset the random pointer and the streaming pointer both read back as 0, and `bus_ready` and `bus_rdata` are 0 while reset is held.
- R2: A write is acknowledged by `bus_ready` in the same cycle it is presented. A read is acknowledged exactly one cycle later. `bus_rdata` is zero in every cycle that is not a read acknowledge.
- R3: The random pointer register at offset 0x10 is updated only in the byte lanes whose strobe is set (strobe bit i covers data bits 8i+7..8i). It holds a word-aligned byte address reduced modulo the memory size in bytes, and reads back with bits 1..0 and all bits at or above log2(memory bytes) as zero.
- R4: The random data register at offset 0x14 accesses the word at the random pointer. A write changes only the strobed byte lanes of that word. A read returns the strobed lanes and zero in every lane whose strobe is clear.
- R5: Reads and writes of the random data register leave the random pointer unchanged.
- R6: The streaming pointer register at offset 0x18 loads the same way as R3, and a read returns the current pointer including every advance made so far.
- R7: Every read or write of the streaming data register at offset 0x1C uses the word under the streaming pointer with the strobe rules of R4. The pointer then advances by 4 bytes and wraps to 0 after the last word.
- R8: Streaming writes can be issued back to back, one per clock. Writing 0xC000 zero words after setting the streaming pointer to 0 leaves every memory word zero and the pointer at (0xC000*4) modulo the memory size in bytes.
- R9: Writes to any other offset change neither memory nor pointers. Reads of any other offset return 0 with the normal one-cycle wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request, held until `bus_ready` |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | REG_AW | Register byte offset |
| bus_be | input | 4 | Byte strobes, bit i selects data bits 8i+7..8i |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` on reads |
| bus_ready | output | 1 | Access completes in this cycle |

## Verification
A write's effect on memory or on a pointer is due at the rising edge that ends the cycle in which the write was presented. The bench therefore drives each write on a falling edge, checks `bus_ready` 1 ns later in that same cycle, and releases the request just after the next rising edge. A read is presented on a falling edge, at which point the bench expects `bus_ready` and `bus_rdata` to be low. Its data is due in the next cycle, so the bench samples it at the following falling edge, one register stage (the RAM output or pointer snapshot) after issue. Pointer advances are observed only through later reads of the pointer registers, which are therefore always at least two edges after the access that caused them.

// File: rtl/memwin_pkg.sv
// Shared constants, target codes and helpers for the memory window.
// Assumes a 32-bit data bus with four byte strobes.
package memwin_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned BE_W   = DATA_W / 8;

    // Register offsets within the window
    localparam logic [7:0] OFS_RPTR  = 8'h10;
    localparam logic [7:0] OFS_RDATA = 8'h14;
    localparam logic [7:0] OFS_SPTR  = 8'h18;
    localparam logic [7:0] OFS_SDATA = 8'h1C;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_RPTR,
        TGT_RDATA,
        TGT_SPTR,
        TGT_SDATA
    } tgt_e;

    // Expand byte strobes into a bit mask
    function automatic logic [DATA_W-1:0] lane_mask(input logic [BE_W-1:0] be);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < BE_W; i++) begin
            m[8*i +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/memwin_decode.sv
// Offset decoder: maps a register byte offset onto a window target.
// Assumes the full offset is compared, so aliases decode as TGT_NONE.
module memwin_decode
    import memwin_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input  logic [AW-1:0] ofs,
    output tgt_e          tgt
);

    // Compare the offset against each register location
    always_comb begin
        if (ofs == AW'(OFS_RPTR)) begin
            tgt = TGT_RPTR;
        end else if (ofs == AW'(OFS_RDATA)) begin
            tgt = TGT_RDATA;
        end else if (ofs == AW'(OFS_SPTR)) begin
            tgt = TGT_SPTR;
        end else if (ofs == AW'(OFS_SDATA)) begin
            tgt = TGT_SDATA;
        end else begin
            tgt = TGT_NONE;
        end
    end

endmodule

// File: rtl/memwin_ptr.sv
// Word pointer with a byte-lane masked load and an optional step.
// The load takes the pointer bits already sliced out of the bus word.
// Assumes WORD_AW <= 29 so that the byte view has zero padding.
module memwin_ptr #(
    parameter int unsigned WORD_AW = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [WORD_AW-1:0] ld_data,
    input  logic [WORD_AW-1:0] ld_mask,
    input  logic               step,
    output logic [WORD_AW-1:0] word_ptr,
    output logic [31:0]        byte_view
);

    localparam int unsigned PAD_W = 32 - WORD_AW - 2;

    logic [WORD_AW-1:0] nxt;

    // Choose between masked load, step and hold
    always_comb begin
        if (load) begin
            nxt = (word_ptr & ~ld_mask) | (ld_data & ld_mask);
        end else if (step) begin
            nxt = word_ptr + 1'b1;
        end else begin
            nxt = word_ptr;
        end
    end

    // Pointer register, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_ptr <= '0;
        end else begin
            word_ptr <= nxt;
        end
    end

    assign byte_view = {{PAD_W{1'b0}}, word_ptr, 2'b00};

endmodule

// File: rtl/memwin_ram.sv
// Synchronous single-port RAM with per-byte write enables.
// Read data appears one clock after re and holds until the next read.
// Contents are not reset.
module memwin_ram #(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [3:0]    be,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);

    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [7:0] mem [DEPTH];
        logic [7:0] q;

        // One byte lane: strobed write and registered read
        always_ff @(posedge clk) begin
            if (we && be[g]) begin
                mem[addr] <= wdata[8*g +: 8];
            end
            if (re) begin
                q <= mem[addr];
            end
        end

        assign rdata[8*g +: 8] = q;
    end

endmodule

// File: rtl/memwin_top.sv
// Register window onto an internal RAM with a fixed pointer and a
// post-incrementing streaming pointer.
// Assumes the host holds bus_sel and its qualifiers until bus_ready.
// DEPTH must be a power of two.
module memwin_top
    import memwin_pkg::*;
#(
    parameter int unsigned DEPTH  = 1024,
    parameter int unsigned REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready
);

    localparam int unsigned WORD_AW = $clog2(DEPTH);

    tgt_e               tgt;
    tgt_e               pend_tgt;
    logic               rd_pend;
    logic [3:0]         pend_be;
    logic [31:0]        reg_snap;
    logic [31:0]        wmask;
    logic               wr_go;
    logic               rd_go;
    logic               is_data;
    logic [WORD_AW-1:0] r_word;
    logic [WORD_AW-1:0] s_word;
    logic [31:0]        r_view;
    logic [31:0]        s_view;
    logic [WORD_AW-1:0] ram_addr;
    logic [31:0]        ram_q;

    memwin_decode #(.AW(REG_AW)) dec_i (
        .ofs (bus_addr),
        .tgt (tgt)
    );

    assign wmask   = lane_mask(bus_be);
    assign wr_go   = bus_sel && bus_wr;
    assign rd_go   = bus_sel && !bus_wr && !rd_pend;
    assign is_data = (tgt == TGT_RDATA) || (tgt == TGT_SDATA);

    memwin_ptr #(.WORD_AW(WORD_AW)) rptr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_go && (tgt == TGT_RPTR)),
        .ld_data   (bus_wdata[WORD_AW+1:2]),
        .ld_mask   (wmask[WORD_AW+1:2]),
        .step      (1'b0),
        .word_ptr  (r_word),
        .byte_view (r_view)
    );

    memwin_ptr #(.WORD_AW(WORD_AW)) sptr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_go && (tgt == TGT_SPTR)),
        .ld_data   (bus_wdata[WORD_AW+1:2]),
        .ld_mask   (wmask[WORD_AW+1:2]),
        .step      ((wr_go || rd_go) && (tgt == TGT_SDATA)),
        .word_ptr  (s_word),
        .byte_view (s_view)
    );

    assign ram_addr = (tgt == TGT_SDATA) ? s_word : r_word;

    memwin_ram #(.DEPTH(DEPTH), .AW(WORD_AW)) ram_i (
        .clk   (clk),
        .we    (wr_go && is_data),
        .re    (rd_go && is_data),
        .be    (bus_be),
        .addr  (ram_addr),
        .wdata (bus_wdata),
        .rdata (ram_q)
    );

    // Track the read wait state and remember what is being read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend  <= 1'b0;
            pend_tgt <= TGT_NONE;
            pend_be  <= '0;
            reg_snap <= '0;
        end else begin
            rd_pend <= rd_go;
            if (rd_go) begin
                pend_tgt <= tgt;
                pend_be  <= bus_be;
                reg_snap <= (tgt == TGT_RPTR) ? r_view :
                            (tgt == TGT_SPTR) ? s_view : '0;
            end
        end
    end

    // Return read data only in the acknowledge cycle
    always_comb begin
        bus_rdata = '0;
        if (rd_pend) begin
            case (pend_tgt)
                TGT_RDATA, TGT_SDATA: bus_rdata = ram_q & lane_mask(pend_be);
                TGT_RPTR, TGT_SPTR:   bus_rdata = reg_snap;
                default:              bus_rdata = '0;
            endcase
        end
    end

    assign bus_ready = wr_go || rd_pend;

endmodule

// File: rtl/memwin_chk.sv
// Protocol and pointer checker for memwin_top, attached by bind.
module memwin_chk
    import memwin_pkg::*;
#(
    parameter int unsigned REG_AW  = 8,
    parameter int unsigned WORD_AW = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [REG_AW-1:0]  bus_addr,
    input logic [3:0]         bus_be,
    input logic [31:0]        bus_rdata,
    input logic               bus_ready,
    input logic               rd_pend,
    input logic [WORD_AW-1:0] r_word,
    input logic [WORD_AW-1:0] s_word
);

    logic at_rdata;
    logic at_sdata;
    logic at_none;

    assign at_rdata = (bus_addr == REG_AW'(OFS_RDATA));
    assign at_sdata = (bus_addr == REG_AW'(OFS_SDATA));
    assign at_none  = !at_rdata && !at_sdata &&
                      (bus_addr != REG_AW'(OFS_RPTR)) &&
                      (bus_addr != REG_AW'(OFS_SPTR));

    // R2
    wr_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && bus_wr |-> bus_ready);

    // R2
    rd_one_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_wr && !bus_ready |=> bus_ready);

    // R2
    rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |-> bus_rdata == '0);

    // R5
    rptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && at_rdata |=> $stable(r_word));

    // R7
    sptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && at_sdata && !rd_pend |=> s_word == WORD_AW'($past(s_word) + 1'b1));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready && !bus_wr && at_none |-> bus_rdata == '0);

    for (genvar g = 0; g < 4; g++) begin : g_lane_chk
        // R4
        lane_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bus_ready && !bus_wr && (at_rdata || at_sdata) && !bus_be[g]
            |-> bus_rdata[8*g +: 8] == 8'h00);
    end

endmodule

bind memwin_top memwin_chk #(
    .REG_AW  (REG_AW),
    .WORD_AW (WORD_AW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready),
    .rd_pend   (rd_pend),
    .r_word    (r_word),
    .s_word    (s_word)
);

// File: tb/memwin_top_tb.sv
// Self-checking bench for memwin_top with directed and seeded random traffic.
module memwin_top_tb_top;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned DEPTH      = 1024;
    localparam int unsigned MEM_BYTES  = DEPTH * 4;
    localparam int unsigned FILL_WORDS = 32'hC000;
    localparam int unsigned WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;

    int unsigned checks = 0;
    int unsigned failures = 0;
    int unsigned wr_ack_bad = 0;
    int unsigned rd_wait_bad = 0;
    int unsigned cycles = 0;

    logic [31:0] exp_mem [DEPTH];
    logic [31:0] exp_r = '0;
    logic [31:0] exp_s = '0;

    memwin_top #(.DEPTH(DEPTH), .REG_AW(8)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] bmask(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
        return m;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                          input logic [3:0] be);
        return (o & ~bmask(be)) | (n & bmask(be));
    endfunction

    function automatic logic [31:0] align(input logic [31:0] a);
        return a & (MEM_BYTES - 1) & ~32'h3;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] ofs, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ofs; bus_be = be; bus_wdata = d;
        #1;
        if (bus_ready !== 1'b1) wr_ack_bad++;
        @(posedge clk);
        #1;
        bus_sel = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] ofs, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ofs; bus_be = be;
        #1;
        if (bus_ready !== 1'b0 || bus_rdata !== 32'h0) rd_wait_bad++;
        @(negedge clk);
        if (bus_ready !== 1'b1) rd_wait_bad++;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // Model-tracked accesses
    task automatic m_wr_rptr(input logic [31:0] d, input logic [3:0] be);
        do_write(8'h10, d, be);
        exp_r = align(merge(exp_r, d, be));
    endtask

    task automatic m_wr_sptr(input logic [31:0] d, input logic [3:0] be);
        do_write(8'h18, d, be);
        exp_s = align(merge(exp_s, d, be));
    endtask

    task automatic m_wr_rdata(input logic [31:0] d, input logic [3:0] be);
        do_write(8'h14, d, be);
        exp_mem[exp_r >> 2] = merge(exp_mem[exp_r >> 2], d, be);
    endtask

    task automatic m_wr_sdata(input logic [31:0] d, input logic [3:0] be);
        do_write(8'h1C, d, be);
        exp_mem[exp_s >> 2] = merge(exp_mem[exp_s >> 2], d, be);
        exp_s = align(exp_s + 4);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        failures++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] d;
        logic [3:0]  be;
        int unsigned op;
        int unsigned bad;

        rd = $urandom(32'h1F2E3D4C);

        // R1: state while reset is held
        repeat (4) @(negedge clk);
        check("R1 ready in reset", {31'h0, bus_ready}, 32'h0);
        check("R1 rdata in reset", bus_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        do_read(8'h10, 4'hF, rd);
        check("R1 random pointer after reset", rd, 32'h0);
        do_read(8'h18, 4'hF, rd);
        check("R1 streaming pointer after reset", rd, 32'h0);

        // R3: full load is aligned and wrapped, partial load keeps other lanes
        m_wr_rptr(32'hFFFF_FFFF, 4'hF);
        do_read(8'h10, 4'hF, rd);
        check("R3 pointer aligned and wrapped", rd, 32'h0000_0FFC);
        m_wr_rptr(32'h0000_0012, 4'b0001);
        do_read(8'h10, 4'hF, rd);
        check("R3 byte-lane load", rd, exp_r);

        // R7: stream-fill every word, pointer wraps to 0
        m_wr_sptr(32'h0, 4'hF);
        for (int i = 0; i < DEPTH; i++) begin
            m_wr_sdata(32'(i) * 32'h9E37_79B1 ^ 32'h5A5A_0F0F, 4'hF);
        end
        do_read(8'h18, 4'hF, rd);
        check("R7 pointer wrap after full pass", rd, 32'h0);

        // R6: live pointer readback after a few advances
        m_wr_sptr(32'h0000_0FF8, 4'hF);
        m_wr_sdata(32'h1111_2222, 4'hF);
        do_read(8'h18, 4'hF, rd);
        check("R6 live streaming pointer", rd, 32'h0000_0FFC);
        do_read(8'h1C, 4'hF, rd);
        check("R7 stream read of last word", rd, exp_mem[DEPTH-1]);
        exp_s = align(exp_s + 4);
        do_read(8'h18, 4'hF, rd);
        check("R7 pointer wrap after read", rd, 32'h0);

        // R4: strobed write and masked read
        m_wr_rptr(32'h0000_0040, 4'hF);
        m_wr_rdata(32'hAABB_CCDD, 4'b0101);
        do_read(8'h14, 4'hF, rd);
        check("R4 strobed write merge", rd, exp_mem[16]);
        do_read(8'h14, 4'b0010, rd);
        check("R4 masked read lane 1", rd, exp_mem[16] & 32'h0000_FF00);

        // R5: data accesses leave the random pointer alone
        do_read(8'h10, 4'hF, rd);
        check("R5 random pointer unchanged", rd, 32'h0000_0040);

        // R9: unmapped offsets
        do_write(8'h04, 32'hDEAD_BEEF, 4'hF);
        do_write(8'h1D, 32'hDEAD_BEEF, 4'hF);
        do_read(8'h04, 4'hF, rd);
        check("R9 unmapped read", rd, 32'h0);
        do_read(8'h10, 4'hF, rd);
        check("R9 random pointer untouched", rd, exp_r);
        do_read(8'h18, 4'hF, rd);
        check("R9 streaming pointer untouched", rd, exp_s);
        do_read(8'h14, 4'hF, rd);
        check("R9 memory untouched", rd, exp_mem[exp_r >> 2]);

        // Seeded random mix of all registers
        for (int n = 0; n < 600; n++) begin
            op = $urandom % 9;
            d  = $urandom;
            be = 4'($urandom);
            case (op)
                0: m_wr_rptr(d, be);
                1: m_wr_sptr(d, be);
                2: m_wr_rdata(d, be);
                3: m_wr_sdata(d, be);
                4: begin
                    do_read(8'h14, be, rd);
                    check("R4 random data read", rd, exp_mem[exp_r >> 2] & bmask(be));
                end
                5: begin
                    do_read(8'h1C, be, rd);
                    check("R7 random stream read", rd, exp_mem[exp_s >> 2] & bmask(be));
                    exp_s = align(exp_s + 4);
                end
                6: begin
                    do_read(8'h10, be, rd);
                    check("R3 random pointer read", rd, exp_r);
                end
                7: begin
                    do_read(8'h18, be, rd);
                    check("R6 streaming pointer read", rd, exp_s);
                end
                default: begin
                    do_write(8'h08, d, be);
                    do_read(8'h0C, be, rd);
                    check("R9 random unmapped read", rd, 32'h0);
                end
            endcase
        end

        // R8: back-to-back zero fill of 0xC000 words
        m_wr_sptr(32'h0, 4'hF);
        for (int i = 0; i < FILL_WORDS; i++) begin
            m_wr_sdata(32'h0, 4'hF);
        end
        do_read(8'h18, 4'hF, rd);
        check("R8 pointer after zero fill", rd, (FILL_WORDS * 4) % MEM_BYTES);
        bad = 0;
        m_wr_sptr(32'h0, 4'hF);
        for (int i = 0; i < DEPTH; i++) begin
            do_read(8'h1C, 4'hF, rd);
            if (rd !== 32'h0) bad++;
        end
        check("R8 nonzero words after fill", bad, 32'h0);

        // R2: handshake timing across the whole run
        check("R2 write acknowledge misses", wr_ack_bad, 32'h0);
        check("R2 read wait-state errors", rd_wait_bad, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule